// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves a control transfer in one clock. Each request presents the five arithmetic flags (zero, carry, sign, overflow, parity), a 5-bit condition selector, a 2-bit jump kind, a 32-bit operand and the current instruction pointer and code segment. The instruction pointer given is the one that follows the branch instruction. One registered cycle later, the unit reports whether the transfer is taken, along with the instruction pointer and code segment to use next.

The condition selector covers three groups. The first tests a single flag, either set or clear. The second is the signed comparisons, built from zero, sign and overflow. The third is the unsigned comparisons, built from carry and zero. Selector 0 means "always". Unused selector values never take the transfer.

The jump kind picks how the target is formed:

- An 8-bit signed displacement.
- A 16-bit signed displacement.
- A 16-bit absolute offset, from a register or memory word.
- A far offset plus segment pair, which also replaces the code segment.

Instruction fetch and the assembly of displacement bytes happen outside this unit.

Top module: `branch_resolver`

## Requirements
- R1: While reset is asserted, and after it is released, `res_valid`, `res_taken`, `res_ip` and `res_cs` are all zero until the first request.
- R2: Single-flag selectors are taken as follows.
  - 1: zero set; 2: zero clear.
  - 3: carry set; 4: carry clear.
  - 5: sign set; 6: sign clear.
  - 7: overflow set; 8: overflow clear.
  - 9: parity set; 10: parity clear.
- R3: Signed selectors are taken as follows.
  - 11 (greater): zero clear and sign equal to overflow.
  - 12 (less or equal): zero set, or sign different from overflow.
  - 13 (greater or equal): sign equal to overflow.
  - 14 (less): sign different from overflow.
- R4: Unsigned selectors are taken as follows.
  - 15 (above): carry and zero both clear.
  - 16 (below or equal): carry or zero set.
- R5: Selector 0 is always taken. Selectors 17 to 31 are never taken, whatever the flags.
- R6: Jump kind 0 (short), when taken, gives `res_ip = ip_next + sign-extended operand[7:0]` modulo 2^16, with the code segment unchanged.
- R7: Jump kind 1 (near relative), when taken, gives `res_ip = ip_next + operand[15:0]` modulo 2^16, with the code segment unchanged.
- R8: Jump kind 2 (near indirect), when taken, gives `res_ip = operand[15:0]`, with the code segment unchanged.
- R9: Jump kind 3 (far), when taken, gives `res_ip = operand[15:0]` and `res_cs = operand[31:16]`. No other kind ever changes the code segment.
- R10: A request that is not taken returns `res_ip = ip_next` and `res_cs = cs_cur`.
- R11: A request sampled at one rising edge appears on the outputs with `res_valid` high after that edge. With `req_valid` low, `res_valid` falls and `res_taken`, `res_ip` and `res_cs` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| flag_zero | input | 1 | Zero flag |
| flag_carry | input | 1 | Carry flag |
| flag_sign | input | 1 | Sign flag |
| flag_ovf | input | 1 | Overflow flag |
| flag_parity | input | 1 | Parity flag |
| cond_sel | input | 5 | Condition selector |
| jump_kind | input | 2 | 0 short, 1 near relative, 2 near indirect, 3 far |
| operand | input | 32 | Displacement or offset in [15:0], far segment in [31:16] |
| ip_next | input | 16 | Instruction pointer after the branch instruction |
| cs_cur | input | 16 | Current code segment |
| res_valid | output | 1 | Result present |
| res_taken | output | 1 | Transfer taken |
| res_ip | output | 16 | Next instruction pointer |
| res_cs | output | 16 | Next code segment |

## Verification
The result register is the only state in the unit, so a wrong internal value shows on `res_taken`, `res_ip` or `res_cs` in the cycle right after the request that caused it. There are no later cycles in which such a fault could stay hidden. A fault in the shared adder shows as a wrong `res_ip` only for the relative kinds. A fault in segment selection shows as `res_cs` moving on a short or near jump. A stuck or swapped condition decode is exposed by sweeping every selector against all 32 flag patterns.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [1:0] {
        KIND_SHORT    = 2'd0,
        KIND_NEAR_REL = 2'd1,
        KIND_NEAR_IND = 2'd2,
        KIND_FAR      = 2'd3
    } jump_kind_e;

    localparam int COND_W = 5;

    typedef enum logic [COND_W-1:0] {
        C_ALWAYS = 5'd0,
        C_ZERO   = 5'd1,
        C_NZERO  = 5'd2,
        C_CARRY  = 5'd3,
        C_NCARRY = 5'd4,
        C_SIGN   = 5'd5,
        C_NSIGN  = 5'd6,
        C_OVF    = 5'd7,
        C_NOVF   = 5'd8,
        C_PAR    = 5'd9,
        C_NPAR   = 5'd10,
        C_SGT    = 5'd11,
        C_SLE    = 5'd12,
        C_SGE    = 5'd13,
        C_SLT    = 5'd14,
        C_UA     = 5'd15,
        C_UBE    = 5'd16
    } cond_e;

    localparam int NUM_FLAGS = 5;

    typedef struct packed {
        logic parity;
        logic ovf;
        logic sign;
        logic carry;
        logic zero;
    } flags_t;

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
(
    input  flags_t            flags,
    input  logic [COND_W-1:0] sel,
    output logic              hit
);
    localparam int SINGLE_N = 2 * NUM_FLAGS;

    logic [NUM_FLAGS-1:0] flag_vec;
    logic [SINGLE_N-1:0]  single_hit;
    logic                 s_eq_o;

    assign flag_vec = flags;
    assign s_eq_o   = (flags.sign == flags.ovf);

    // Even slot: flag set; odd slot: flag clear. Selector k (1..10) maps to slot k-1.
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_single
        assign single_hit[2*i]   = flag_vec[i];
        assign single_hit[2*i+1] = ~flag_vec[i];
    end

    always_comb begin
        hit = 1'b0;
        if (sel == C_ALWAYS) begin
            hit = 1'b1;
        end else if (sel <= C_NPAR) begin
            hit = single_hit[sel - 5'd1];
        end else begin
            unique case (sel)
                C_SGT:   hit = ~flags.zero & s_eq_o;
                C_SLE:   hit = flags.zero | ~s_eq_o;
                C_SGE:   hit = s_eq_o;
                C_SLT:   hit = ~s_eq_o;
                C_UA:    hit = ~flags.carry & ~flags.zero;
                C_UBE:   hit = flags.carry | flags.zero;
                default: hit = 1'b0;
            endcase
        end
    end

    // R5: selectors past the defined range never hit.
    always_comb begin
        if (sel > C_UBE) a_r5_undefined_never_hit: assert (!hit);
    end
endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc
    import bru_pkg::*;
#(
    parameter int IP_W    = 16,
    parameter int SEG_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic [1:0]            kind,
    input  logic [IP_W+SEG_W-1:0] operand,
    input  logic [IP_W-1:0]       ip_base,
    input  logic [SEG_W-1:0]      cs_base,
    output logic [IP_W-1:0]       tgt_ip,
    output logic [SEG_W-1:0]      tgt_cs
);
    localparam int EXT_W = IP_W - SHORT_W;

    logic [IP_W-1:0] short_ext;
    logic [IP_W-1:0] addend;
    logic [IP_W-1:0] rel_sum;
    logic [IP_W-1:0] span;

    assign short_ext = {{EXT_W{operand[SHORT_W-1]}}, operand[SHORT_W-1:0]};
    // One adder serves both relative kinds.
    assign addend    = (jump_kind_e'(kind) == KIND_SHORT) ? short_ext : operand[IP_W-1:0];
    assign rel_sum   = ip_base + addend;

    always_comb begin
        tgt_cs = cs_base;
        unique case (jump_kind_e'(kind))
            KIND_SHORT, KIND_NEAR_REL: tgt_ip = rel_sum;
            KIND_NEAR_IND:             tgt_ip = operand[IP_W-1:0];
            KIND_FAR: begin
                tgt_ip = operand[IP_W-1:0];
                tgt_cs = operand[IP_W+SEG_W-1:IP_W];
            end
            default:                   tgt_ip = ip_base;
        endcase
    end

    // R6: a short target stays within -128..+127 of the base pointer.
    assign span = tgt_ip - ip_base;
    always_comb begin
        if (jump_kind_e'(kind) == KIND_SHORT)
            a_r6_short_in_range: assert ((&span[IP_W-1:SHORT_W-1]) || !(|span[IP_W-1:SHORT_W-1]));
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import bru_pkg::*;
#(
    parameter int IP_W    = 16,
    parameter int SEG_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  flag_zero,
    input  logic                  flag_carry,
    input  logic                  flag_sign,
    input  logic                  flag_ovf,
    input  logic                  flag_parity,
    input  logic [4:0]            cond_sel,
    input  logic [1:0]            jump_kind,
    input  logic [IP_W+SEG_W-1:0] operand,
    input  logic [IP_W-1:0]       ip_next,
    input  logic [SEG_W-1:0]      cs_cur,
    output logic                  res_valid,
    output logic                  res_taken,
    output logic [IP_W-1:0]       res_ip,
    output logic [SEG_W-1:0]      res_cs
);
    typedef struct packed {
        logic             valid;
        logic             taken;
        logic [IP_W-1:0]  ip;
        logic [SEG_W-1:0] cs;
    } res_t;

    flags_t           flags;
    logic             cond_hit;
    logic [IP_W-1:0]  tgt_ip;
    logic [SEG_W-1:0] tgt_cs;
    res_t             res_d, res_q;

    assign flags = '{parity: flag_parity, ovf: flag_ovf, sign: flag_sign,
                     carry: flag_carry, zero: flag_zero};

    bru_cond_eval i_cond (
        .flags (flags),
        .sel   (cond_sel),
        .hit   (cond_hit)
    );

    bru_target_calc #(
        .IP_W    (IP_W),
        .SEG_W   (SEG_W),
        .SHORT_W (SHORT_W)
    ) i_target (
        .kind    (jump_kind),
        .operand (operand),
        .ip_base (ip_next),
        .cs_base (cs_cur),
        .tgt_ip  (tgt_ip),
        .tgt_cs  (tgt_cs)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.taken = cond_hit;
            res_d.ip    = cond_hit ? tgt_ip : ip_next;
            res_d.cs    = cond_hit ? tgt_cs : cs_cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_taken = res_q.taken;
    assign res_ip    = res_q.ip;
    assign res_cs    = res_q.cs;

    // R11: a sampled request yields a result on the next cycle.
    a_r11_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R11: outputs hold while idle.
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(res_ip) && $stable(res_cs) && $stable(res_taken) && !res_valid));

    // R10: a not-taken result passes pointer and segment through.
    a_r10_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cond_hit) |=> (res_ip == $past(ip_next) && res_cs == $past(cs_cur)));

    // R9: only a far request may change the code segment.
    a_r9_segment_only_far: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && jump_kind != 2'd3) |=> (res_cs == $past(cs_cur)));

    // R5: selector 0 is always taken.
    a_r5_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cond_sel == 5'd0) |=> res_taken);
endmodule

// File: tb/test_branch_resolver.sv
module test_branch_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        fz = 1'b0, fc = 1'b0, fs = 1'b0, fo = 1'b0, fp = 1'b0;
    logic [4:0]  cond_sel = '0;
    logic [1:0]  jump_kind = '0;
    logic [31:0] operand = '0;
    logic [15:0] ip_next = '0;
    logic [15:0] cs_cur = '0;
    logic        res_valid, res_taken;
    logic [15:0] res_ip, res_cs;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    branch_resolver i_branch_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .flag_zero(fz), .flag_carry(fc), .flag_sign(fs), .flag_ovf(fo), .flag_parity(fp),
        .cond_sel(cond_sel), .jump_kind(jump_kind), .operand(operand),
        .ip_next(ip_next), .cs_cur(cs_cur),
        .res_valid(res_valid), .res_taken(res_taken), .res_ip(res_ip), .res_cs(res_cs)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Condition model written from R2..R5; flag pattern f = {p,o,s,c,z}.
    function automatic bit model_taken(input logic [4:0] sel, input logic [4:0] f);
        bit z = f[0], c = f[1], s = f[2], o = f[3], p = f[4];
        case (sel)
            5'd0:  return 1'b1;
            5'd1:  return z;
            5'd2:  return !z;
            5'd3:  return c;
            5'd4:  return !c;
            5'd5:  return s;
            5'd6:  return !s;
            5'd7:  return o;
            5'd8:  return !o;
            5'd9:  return p;
            5'd10: return !p;
            5'd11: return (z == 0) && (s == o);
            5'd12: return z || (s != o);
            5'd13: return s == o;
            5'd14: return s != o;
            5'd15: return !c && !z;
            5'd16: return c || z;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string sel_tag(input logic [4:0] sel);
        if (sel == 0 || sel > 16) return "R5";
        if (sel <= 10)            return "R2";
        if (sel <= 14)            return "R3";
        return "R4";
    endfunction

    // Drive one request on a falling edge; the result is registered on the next rising edge.
    task automatic issue(input logic [4:0] sel, input logic [4:0] f, input logic [1:0] kind,
                         input logic [31:0] opnd, input logic [15:0] ip, input logic [15:0] cs);
        @(negedge clk);
        req_valid = 1'b1;
        cond_sel  = sel;
        {fp, fo, fs, fc, fz} = f;
        jump_kind = kind;
        operand   = opnd;
        ip_next   = ip;
        cs_cur    = cs;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "valid", {31'd0, res_valid}, 32'd0);
        check("R1", "taken", {31'd0, res_taken}, 32'd0);
        check("R1", "ip", {16'd0, res_ip}, 32'd0);
        check("R1", "cs", {16'd0, res_cs}, 32'd0);
    endtask

    task automatic t_conditions;
        for (int sel = 0; sel < 32; sel++) begin
            for (int f = 0; f < 32; f++) begin
                bit exp_t;
                exp_t = model_taken(5'(sel), 5'(f));
                issue(5'(sel), 5'(f), 2'd1, 32'h0000_0010, 16'h1000, 16'h2000);
                check(sel_tag(5'(sel)), "taken", {31'd0, res_taken}, {31'd0, exp_t});
                check("R11", "valid", {31'd0, res_valid}, 32'd1);
                if (!exp_t) check("R10", "ip", {16'd0, res_ip}, 32'h1000);
                else        check("R7", "ip", {16'd0, res_ip}, 32'h1010);
            end
        end
    endtask

    task automatic t_short;
        issue(5'd0, 5'd0, 2'd0, 32'hFFFF_FF7F, 16'h1234, 16'h0042);
        check("R6", "short +127 ip", {16'd0, res_ip}, 32'h12B3);
        check("R6", "short cs", {16'd0, res_cs}, 32'h0042);
        issue(5'd0, 5'd0, 2'd0, 32'h0000_0080, 16'h1234, 16'h0042);
        check("R6", "short -128 ip", {16'd0, res_ip}, 32'h11B4);
        issue(5'd0, 5'd0, 2'd0, 32'h0000_0010, 16'hFFF8, 16'h0042);
        check("R6", "short wrap ip", {16'd0, res_ip}, 32'h0008);
        issue(5'd0, 5'd0, 2'd0, 32'h0000_00F0, 16'h0004, 16'h0042);
        check("R6", "short wrap down ip", {16'd0, res_ip}, 32'hFFF4);
    endtask

    task automatic t_near;
        issue(5'd0, 5'd0, 2'd1, 32'hABCD_8000, 16'h1000, 16'h0300);
        check("R7", "near -32768 ip", {16'd0, res_ip}, 32'h9000);
        check("R7", "near cs", {16'd0, res_cs}, 32'h0300);
        issue(5'd0, 5'd0, 2'd1, 32'h0000_7FFF, 16'h9000, 16'h0300);
        check("R7", "near wrap ip", {16'd0, res_ip}, 32'h0FFF);
    endtask

    task automatic t_indirect;
        issue(5'd0, 5'd0, 2'd2, 32'h5555_C0DE, 16'h1111, 16'h0777);
        check("R8", "indirect ip", {16'd0, res_ip}, 32'hC0DE);
        check("R8", "indirect cs", {16'd0, res_cs}, 32'h0777);
    endtask

    task automatic t_far;
        issue(5'd0, 5'd0, 2'd3, 32'hF000_FFF0, 16'h1111, 16'h0777);
        check("R9", "far ip", {16'd0, res_ip}, 32'hFFF0);
        check("R9", "far cs", {16'd0, res_cs}, 32'hF000);
        // Far request not taken (selector 1 with zero clear) keeps the segment.
        issue(5'd1, 5'd0, 2'd3, 32'hF000_FFF0, 16'h2222, 16'h0888);
        check("R10", "far not taken ip", {16'd0, res_ip}, 32'h2222);
        check("R10", "far not taken cs", {16'd0, res_cs}, 32'h0888);
    endtask

    task automatic t_idle_hold;
        issue(5'd0, 5'd0, 2'd3, 32'h1357_2468, 16'h0001, 16'h0002);
        @(negedge clk);
        cond_sel = 5'd0; jump_kind = 2'd3; operand = 32'hDEAD_BEEF; ip_next = 16'h4444; cs_cur = 16'h5555;
        @(negedge clk);
        check("R11", "idle valid", {31'd0, res_valid}, 32'd0);
        check("R11", "idle ip hold", {16'd0, res_ip}, 32'h2468);
        check("R11", "idle cs hold", {16'd0, res_cs}, 32'h1357);
        check("R11", "idle taken hold", {31'd0, res_taken}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_conditions();
        t_short();
        t_near();
        t_indirect();
        t_far();
        t_idle_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule